// File: doc/BRIEF.md
# Keyboard Scan Responder Sequencer

This block sits on the keyboard end of a shared clock-and-strobe link. A host first reads the position of every key, one key per host clock, and then reads a small set of analog controllers. Every key reports one of three positions as a 2-bit code. On a low-to-high edge of the gate input, the block captures all key codes at once. Each later host clock presents the next key's code on a three-level select output, `levelSel`. An external chooser uses that select to drive ground, a high level or a low level onto the data line.

When the host raises the analog strobe, the block empties the key chain and enters analog mode. In analog mode the level select stays at the middle level, and host clocks step a channel address for an 8-way analog selector. The channel order is Y, then X, then pressure, and the remaining addresses are reserved. The next gate edge puts the block back in digital mode.

All three link inputs are synchronized to the system clock. Only their rising edges cause any action.

Top module: `kbdScanResponder`

## Requirements
- R1: A low-to-high edge on `gateIn` captures `keyStates` into the chain. It also clears `analogMode` and sets `chanAddr` to 0. Key 0 (bits [1:0]) then becomes the current key.
- R2: In digital mode, the current key code sets `levelSel` as follows: 00 (transition) gives 00 (middle level), 01 (key up) gives 01 (high level) and 10 (key down) gives 10 (low level). Key k sits at bits [2k+1:2k].
- R3: In digital mode, each rising edge of `hostClk` moves the readout forward by exactly one key.
- R4: `levelSel` holds 00 in three cases: before any capture, after the last key has been read, and on any further host clocks until the next strobe or gate.
- R5: A rising edge of `hostStrobe` sets `analogMode` to 1, empties the key chain and sets `chanAddr` to 0. While `analogMode` is 1, `levelSel` is 00.
- R6: In analog mode, each rising edge of `hostClk` adds one to `chanAddr`. Address 0 is Y, 1 is X and 2 is pressure; addresses 3 to 7 are reserved.
- R7: `chanAddr` saturates at 7. Further host clocks leave it at 7.
- R8: A current key code of 11 gives `levelSel` 00 and sets `codeErr`. `codeErr` stays set until reset.
- R9: After reset, `analogMode` is 0, `chanAddr` is 0, `levelSel` is 00 and `codeErr` is 0.
- R10: An input held high causes exactly one action, so a long host clock advances the readout once.
- R11: When edges are detected in the same cycle, the strobe wins over the gate, and the gate wins over the host clock.
- R12: A strobe that arrives while the block is already in analog mode restarts `chanAddr` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostClk | input | 1 | Host clock; each rising edge advances the key readout or the channel |
| hostStrobe | input | 1 | Analog strobe from the host |
| gateIn | input | 1 | Gate/latch; a rising edge captures the key codes |
| keyStates | input | 2*NUM_KEYS | Per-key 2-bit codes; key k is at bits [2k+1:2k] |
| levelSel | output | 2 | Level select: 00 middle, 01 high, 10 low |
| chanAddr | output | CHAN_BITS | Analog channel address |
| analogMode | output | 1 | 1 while the analog channel selector is active |
| codeErr | output | 1 | Sticky flag for an invalid key code |

## Verification
The bench uses six keys. The first four keys take every combination of the four codes, and the last two follow an arithmetic pattern. Every captured pattern is read one key at a time, so an off-by-one in the shift, a swap in the level map or a wrong field position gives a wrong level at a known key. After each readout, the bench checks the idle levels past the last key and then enters analog mode. Some passes step the channel past its top address, which separates saturation from wraparound. Other patterns test the ordering rules:
- edges that arrive together, which check the priority order;
- a strobe in the middle of a readout;
- a repeated strobe;
- a host clock held high for many cycles, which checks that only the edge acts.

// File: rtl/kbdScanPkg.sv
package kbdScanPkg;

  // Current key codes as captured from the keyboard
  localparam logic [1:0] CODE_TRANS = 2'b00;
  localparam logic [1:0] CODE_UP    = 2'b01;
  localparam logic [1:0] CODE_DOWN  = 2'b10;
  localparam logic [1:0] CODE_BAD   = 2'b11;

  // Select driven to the external three-level chooser
  typedef enum logic [1:0] {
    LVL_MID  = 2'b00,
    LVL_HIGH = 2'b01,
    LVL_LOW  = 2'b10
  } levelT;

  // Command strobes from control to datapath
  typedef struct packed {
    logic loadChain;
    logic shiftChain;
    logic clearChain;
    logic resetChan;
    logic stepChan;
  } scanCmdT;

endpackage

// File: rtl/linkEdgeSync.sv
module linkEdgeSync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] risePulse
);

  // Each link input gets its own two-stage synchronizer and edge detector
  for (genvar g = 0; g < WIDTH; g++) begin : gLane
    logic syncA, syncB, lastB;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA <= 1'b0;
        syncB <= 1'b0;
        lastB <= 1'b0;
      end else begin
        syncA <= rawIn[g];
        syncB <= syncA;
        lastB <= syncB;
      end
    end

    assign risePulse[g] = syncB & ~lastB;

    // A rising-edge pulse never lasts two cycles in a row
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
      risePulse[g] |=> !risePulse[g]);  // R10
  end

endmodule

// File: rtl/scanCtrl.sv
module scanCtrl
  import kbdScanPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    gateRise,
  input  logic    clkRise,
  input  logic    strobeRise,
  output scanCmdT cmd,
  output logic    analogMode
);

  logic modeNext;

  // Priority: strobe, then gate, then host clock
  always_comb begin
    cmd = '0;
    if (strobeRise) begin
      cmd.clearChain = 1'b1;
      cmd.resetChan  = 1'b1;
    end else if (gateRise) begin
      cmd.loadChain  = 1'b1;
      cmd.resetChan  = 1'b1;
    end else if (clkRise) begin
      if (analogMode) cmd.stepChan   = 1'b1;
      else            cmd.shiftChain = 1'b1;
    end
  end

  always_comb begin
    modeNext = analogMode;
    if (strobeRise)    modeNext = 1'b1;
    else if (gateRise) modeNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) analogMode <= 1'b0;
    else       analogMode <= modeNext;
  end

  AST_STROBE_ENTERS_ANALOG: assert property (@(posedge clk) disable iff (!rstN)
    strobeRise |=> analogMode);  // R5

  AST_GATE_LEAVES_ANALOG: assert property (@(posedge clk) disable iff (!rstN)
    (gateRise && !strobeRise) |=> !analogMode);  // R1

  AST_CLOCK_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (clkRise && !gateRise && !strobeRise) |=> $stable(analogMode));  // R11

endmodule

// File: rtl/scanDatapath.sv
module scanDatapath
  import kbdScanPkg::*;
#(
  parameter int NUM_KEYS  = 61,
  parameter int CHAN_BITS = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  scanCmdT               cmd,
  input  logic                  analogMode,
  input  logic [2*NUM_KEYS-1:0] keyStates,
  output levelT                 levelSel,
  output logic [CHAN_BITS-1:0]  chanAddr,
  output logic                  codeErr
);

  localparam int CHAIN_W = 2 * NUM_KEYS;
  localparam int POS_W   = $clog2(NUM_KEYS + 1);
  localparam logic [POS_W-1:0]     POS_END  = POS_W'(NUM_KEYS);
  localparam logic [CHAN_BITS-1:0] CHAN_TOP = '1;

  logic [CHAIN_W-1:0]   chain;
  logic [POS_W-1:0]     posCnt;
  logic [1:0]           curCode;

  // Key chain: parallel capture, then two bits per step, zero fill
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain  <= '0;
      posCnt <= POS_END;
    end else if (cmd.clearChain) begin
      chain  <= '0;
      posCnt <= POS_END;
    end else if (cmd.loadChain) begin
      chain  <= keyStates;
      posCnt <= '0;
    end else if (cmd.shiftChain) begin
      chain  <= {2'b00, chain[CHAIN_W-1:2]};
      if (posCnt != POS_END) posCnt <= posCnt + 1'b1;
    end
  end

  assign curCode = chain[1:0];

  // Three-level mapping; quiet in analog mode and for the invalid code
  always_comb begin
    levelSel = LVL_MID;
    if (!analogMode) begin
      unique case (curCode)
        CODE_UP:   levelSel = LVL_HIGH;
        CODE_DOWN: levelSel = LVL_LOW;
        default:   levelSel = LVL_MID;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                       codeErr <= 1'b0;
    else if (!analogMode && curCode == CODE_BAD)     codeErr <= 1'b1;
  end

  // Analog channel counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        chanAddr <= '0;
    else if (cmd.resetChan)                           chanAddr <= '0;
    else if (cmd.stepChan && chanAddr != CHAN_TOP)    chanAddr <= chanAddr + 1'b1;
  end

  AST_CHAN_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepChan && chanAddr == CHAN_TOP) |=> chanAddr == CHAN_TOP);  // R7

  AST_CHAN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepChan && !cmd.resetChan && chanAddr != CHAN_TOP)
      |=> chanAddr == $past(chanAddr) + 1'b1);  // R6

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clearChain |=> (curCode == CODE_TRANS && chanAddr == '0));  // R5

  AST_EXHAUSTED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (posCnt == POS_END) |-> curCode == CODE_TRANS);  // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    codeErr |=> codeErr);  // R8

  AST_BAD_SETS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (!analogMode && curCode == CODE_BAD) |=> codeErr);  // R8

endmodule

// File: rtl/kbdScanResponder.sv
module kbdScanResponder
  import kbdScanPkg::*;
#(
  parameter int NUM_KEYS  = 61,
  parameter int CHAN_BITS = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostClk,
  input  logic                  hostStrobe,
  input  logic                  gateIn,
  input  logic [2*NUM_KEYS-1:0] keyStates,
  output logic [1:0]            levelSel,
  output logic [CHAN_BITS-1:0]  chanAddr,
  output logic                  analogMode,
  output logic                  codeErr
);

  logic [2:0] risePulse;
  scanCmdT    cmd;
  levelT      levelInt;

  linkEdgeSync #(.WIDTH(3)) uSync (
    .clk       (clk),
    .rstN      (rstN),
    .rawIn     ({hostStrobe, gateIn, hostClk}),
    .risePulse (risePulse)
  );

  scanCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .gateRise   (risePulse[1]),
    .clkRise    (risePulse[0]),
    .strobeRise (risePulse[2]),
    .cmd        (cmd),
    .analogMode (analogMode)
  );

  scanDatapath #(.NUM_KEYS(NUM_KEYS), .CHAN_BITS(CHAN_BITS)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .analogMode (analogMode),
    .keyStates  (keyStates),
    .levelSel   (levelInt),
    .chanAddr   (chanAddr),
    .codeErr    (codeErr)
  );

  assign levelSel = levelInt;

  AST_ANALOG_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    analogMode |-> levelSel == 2'b00);  // R5

endmodule

// File: tb/sim_kbdScanResponder.sv
module sim_kbdScanResponder;

  localparam int NK = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostClk = 1'b0, hostStrobe = 1'b0, gateIn = 1'b0;
  logic [2*NK-1:0] keyStates = '0;
  logic [1:0]    levelSel;
  logic [2:0]    chanAddr;
  logic          analogMode, codeErr;

  int nCmp = 0, nBad = 0;
  bit errExp = 1'b0;

  always #10 clk = ~clk;

  kbdScanResponder #(.NUM_KEYS(NK), .CHAN_BITS(3)) u0 (
    .clk(clk), .rstN(rstN), .hostClk(hostClk), .hostStrobe(hostStrobe),
    .gateIn(gateIn), .keyStates(keyStates), .levelSel(levelSel),
    .chanAddr(chanAddr), .analogMode(analogMode), .codeErr(codeErr)
  );

  task automatic chk(input string req, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lvlOf(input int code);
    return (code == 1) ? 1 : (code == 2) ? 2 : 0;
  endfunction

  function automatic int keyCode(input int p, input int i);
    return (i < 4) ? ((p >> (2 * i)) & 3) : ((p + i) & 3);
  endfunction

  // Raise chosen inputs for two clocks, drop, then let the result settle
  task automatic pulse(input bit g, input bit c, input bit s);
    @(negedge clk);
    gateIn = g; hostClk = c; hostStrobe = s;
    repeat (2) @(posedge clk);
    @(negedge clk);
    gateIn = 1'b0; hostClk = 1'b0; hostStrobe = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 level", levelSel, 0);
    chk("R9 chan", chanAddr, 0);
    chk("R9 mode", analogMode, 0);
    chk("R9 err", codeErr, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R4 clock before any capture keeps middle level
    pulse(0, 1, 0);
    chk("R4 idle before load", levelSel, 0);

    // Near-exhaustive sweep over key patterns
    for (int p = 0; p < 256; p++) begin
      for (int i = 0; i < NK; i++) keyStates[2*i +: 2] = 2'(keyCode(p, i));
      pulse(1, 0, 0);
      chk("R1 mode", analogMode, 0);
      chk("R1 chan", chanAddr, 0);
      chk("R1 R2 key0 level", levelSel, lvlOf(keyCode(p, 0)));
      if (keyCode(p, 0) == 3) errExp = 1'b1;
      chk("R8 err", codeErr, int'(errExp));
      for (int i = 1; i < NK; i++) begin
        pulse(0, 1, 0);
        chk("R3 R2 key level", levelSel, lvlOf(keyCode(p, i)));
        if (keyCode(p, i) == 3) errExp = 1'b1;
        chk("R8 err", codeErr, int'(errExp));
      end
      for (int k = 0; k < 2; k++) begin
        pulse(0, 1, 0);
        chk("R4 past last key", levelSel, 0);
      end
      pulse(0, 0, 1);
      chk("R5 mode", analogMode, 1);
      chk("R5 chan", chanAddr, 0);
      chk("R5 level", levelSel, 0);
      if (p % 32 == 0) begin
        for (int k = 1; k <= 9; k++) begin
          pulse(0, 1, 0);
          chk(k <= 7 ? "R6 chan step" : "R7 chan saturate", chanAddr, (k > 7) ? 7 : k);
          chk("R5 level quiet", levelSel, 0);
        end
        pulse(0, 0, 1);
        chk("R12 restrobe chan", chanAddr, 0);
        chk("R12 mode", analogMode, 1);
      end else begin
        pulse(0, 1, 0);
        chk("R6 chan X", chanAddr, 1);
      end
    end

    // R10 long host clock advances once
    keyStates = {2'b10, 2'b01, 2'b10, 2'b10, 2'b01, 2'b10};
    pulse(1, 0, 0);
    chk("R10 key0", levelSel, 2);
    @(negedge clk); hostClk = 1'b1;
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk("R10 held clock one step", levelSel, 1);
    hostClk = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 after release", levelSel, 1);

    // R11 strobe beats gate
    pulse(1, 0, 1);
    chk("R11 strobe over gate mode", analogMode, 1);
    chk("R11 strobe over gate level", levelSel, 0);
    // R11 gate beats clock
    pulse(1, 1, 0);
    chk("R11 gate over clock mode", analogMode, 0);
    chk("R11 gate over clock level", levelSel, 2);

    // Strobe mid-readout, then reload
    pulse(0, 1, 0);
    chk("R3 key1", levelSel, 1);
    pulse(0, 0, 1);
    chk("R5 mid strobe mode", analogMode, 1);
    chk("R5 mid strobe chan", chanAddr, 0);
    pulse(0, 1, 0);
    pulse(0, 1, 0);
    chk("R6 chan pressure", chanAddr, 2);
    pulse(1, 0, 0);
    chk("R1 reload mode", analogMode, 0);
    chk("R1 reload chan", chanAddr, 0);
    chk("R1 reload key0", levelSel, 2);

    finishRun();
  end

endmodule